// File: doc/BRIEF.md
# Instruction Repeat Sequencer

This block controls the repetition of one coprocessor instruction. It keeps a 16-bit repeat word. The word holds a 13-bit remaining-iteration count in bits 12..0 and a busy flag in bit 15. The word can be read at all times. A sequence starts in one of two ways. The first is a 5-bit immediate, which loads the count with the value minus one. The second is register mode, which uses the count that an earlier register write left in the word. A count of N yields N+1 executions. The longest sequence is therefore 8192 executions.

After each completed iteration the pipeline pulses a done strobe. The block checks the count for zero. A non-zero count is decremented and the block asks for one more issue. A zero count ends the sequence and clears the flag. An interrupt entry freezes the sequence, and the flag and count stay intact. The matching interrupt return resumes the sequence. A register-mode start in the cycle right after a write to the word is a pipeline hazard. The block reports it and drops that start.

Top module: `rpt_seq_ctrl`

## Requirements
- R1: After a synchronous reset the following all read 0: `rd_word`, `active`, `reissue` and `hazard`.
- R2: While idle, a write loads `wr_data[12:0]` into count bits 12..0 of `rd_word`. The other `wr_data` bits are ignored, and flag bit 15 and bits 14..13 stay 0.
- R3: An immediate start with value k loads k-1 into the count. Values 0 and 1 both load 0. The flag (bit 15) is set only when the loaded count is non-zero.
- R4: A register-mode start keeps the count and sets the flag and `active` when the count is non-zero.
- R5: When `iter_done` arrives while running and the count is non-zero, `reissue` is high in that same cycle, and the count is one lower from the next cycle.
- R6: When `iter_done` arrives while running and the count is zero, `reissue` is low, and the flag and `active` clear on the next cycle. A count of N gives N+1 `iter_done` completions in total.
- R7: `irq_enter` while running drops `active` and holds the count and flag. While held, `iter_done` is ignored. An `iter_done` in the same cycle as `irq_enter` is still counted, but `reissue` stays low.
- R8: `irq_return` while held raises `active` again, and the sequence continues from the held count.
- R9: A write while the flag is set, whether running or held, leaves `rd_word` unchanged.
- R10: A register-mode start in the cycle after an accepted write raises `hazard` in that cycle, and the start is ignored.
- R11: Any start while the flag is set is ignored.
- R12: When immediate and register starts arrive in the same cycle, the immediate start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Repeat-word write strobe |
| wr_data | input | 16 | Repeat-word write data (count in bits 12..0) |
| start_imm | input | 1 | Start a sequence from the immediate |
| imm_val | input | 5 | Immediate repetition value |
| start_reg | input | 1 | Start a sequence from the stored count |
| iter_done | input | 1 | One execution of the repeated instruction completed |
| irq_enter | input | 1 | Interrupt taken |
| irq_return | input | 1 | Interrupt routine finished |
| rd_word | output | 16 | Repeat word: bit 15 flag, bits 12..0 count |
| active | output | 1 | Sequence running and not suspended |
| reissue | output | 1 | Issue the instruction once more (combinational with iter_done) |
| hazard | output | 1 | Register start too close to a write; start dropped |

## Verification
Two situations are hard to reach from the ports. One is an interrupt that lands in the very cycle an iteration completes. The other is a suspended sequence that receives further completions and writes. The vector table reaches both. It first runs a register-mode sequence partway, then interleaves an interrupt entry with stray `iter_done` pulses and a write, then returns. Later it fires `iter_done` and `irq_enter` together and checks the decremented count. Full-length runs of 24 and 256 executions, counted at the ports, confirm the N+1 rule for both start modes.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

    localparam int DEF_CNT_W  = 13;
    localparam int DEF_IMM_W  = 5;
    localparam int DEF_WORD_W = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_IMM  = 2'd1,
        SRC_REG  = 2'd2
    } load_src_t;

    // events produced by the sequencer for the count register
    typedef struct packed {
        logic arm;     // sequence armed this cycle
        logic step;    // count decrements this cycle
        logic finish;  // final iteration completed
        logic hold;    // entering interrupt suspension
        logic resume;  // leaving interrupt suspension
    } seq_evt_t;

    function automatic logic is_busy(input seq_state_t st);
        return st != SEQ_IDLE;
    endfunction

endpackage

// File: rtl/rpt_load_sel.sv
module rpt_load_sel
    import rpt_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int IMM_W = DEF_IMM_W
) (
    input  logic             start_imm,
    input  logic [IMM_W-1:0] imm_val,
    input  logic             start_reg,
    input  logic [CNT_W-1:0] cur_cnt,
    input  logic             wr_recent,
    input  logic             busy,
    output load_src_t        load_src,
    output logic [CNT_W-1:0] load_cnt,
    output logic             load_nonzero,
    output logic             hazard
);

    logic [CNT_W-1:0] imm_ext;
    logic [CNT_W-1:0] imm_minus;

    generate
        if (IMM_W >= CNT_W) begin : g_imm_trunc
            assign imm_ext = imm_val[CNT_W-1:0];
        end else begin : g_imm_zext
            assign imm_ext = {{(CNT_W-IMM_W){1'b0}}, imm_val};
        end
    endgenerate

    always_comb begin
        if (imm_ext == '0) begin
            imm_minus = '0;
        end else begin
            imm_minus = imm_ext - CNT_W'(1);
        end
    end

    assign hazard = start_reg && wr_recent && !busy;

    always_comb begin
        load_src = SRC_NONE;
        load_cnt = cur_cnt;
        if (!busy) begin
            if (start_imm) begin
                load_src = SRC_IMM;
                load_cnt = imm_minus;
            end else if (start_reg && !wr_recent) begin
                load_src = SRC_REG;
                load_cnt = cur_cnt;
            end
        end
    end

    assign load_nonzero = (load_cnt != '0);

endmodule

// File: rtl/rpt_wr_track.sv
module rpt_wr_track (
    input  logic clk,
    input  logic rst,
    input  logic wr_accept,
    output logic wr_recent
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_recent <= 1'b0;
        end else begin
            wr_recent <= wr_accept;
        end
    end

endmodule

// File: rtl/rpt_seq_fsm.sv
module rpt_seq_fsm
    import rpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  load_src_t  load_src,
    input  logic       load_nonzero,
    input  logic       iter_done,
    input  logic       cnt_zero,
    input  logic       irq_enter,
    input  logic       irq_return,
    output seq_state_t state,
    output seq_evt_t   evt,
    output logic       reissue
);

    seq_state_t state_nx;

    always_comb begin
        state_nx = state;
        evt      = '0;
        reissue  = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                if (load_src != SRC_NONE && load_nonzero) begin
                    evt.arm  = 1'b1;
                    state_nx = SEQ_RUN;
                end
            end
            SEQ_RUN: begin
                if (iter_done && cnt_zero) begin
                    evt.finish = 1'b1;
                    state_nx   = SEQ_IDLE;
                end else begin
                    if (iter_done) begin
                        evt.step = 1'b1;
                        reissue  = !irq_enter;
                    end
                    if (irq_enter) begin
                        evt.hold = 1'b1;
                        state_nx = SEQ_HOLD;
                    end
                end
            end
            SEQ_HOLD: begin
                if (irq_return) begin
                    evt.resume = 1'b1;
                    state_nx   = SEQ_RUN;
                end
            end
            default: state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
        end else begin
            state <= state_nx;
        end
    end

endmodule

// File: rtl/rpt_count_reg.sv
module rpt_count_reg
    import rpt_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_accept,
    input  logic [CNT_W-1:0] wr_cnt,
    input  load_src_t        load_src,
    input  logic [CNT_W-1:0] load_cnt,
    input  seq_evt_t         evt,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_zero
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr_accept) begin
            cnt <= wr_cnt;
        end else if (load_src == SRC_IMM) begin
            cnt <= load_cnt;
        end else if (evt.step) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign cnt_zero = (cnt == '0);

endmodule

// File: rtl/rpt_seq_ctrl.sv
module rpt_seq_ctrl
    import rpt_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int IMM_W  = DEF_IMM_W,
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              start_imm,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic              start_reg,
    input  logic              iter_done,
    input  logic              irq_enter,
    input  logic              irq_return,
    output logic [WORD_W-1:0] rd_word,
    output logic              active,
    output logic              reissue,
    output logic              hazard
);

    localparam int PAD_W = WORD_W - CNT_W - 1;

    seq_state_t       state;
    seq_evt_t         evt;
    load_src_t        load_src;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_cnt;
    logic             load_nonzero;
    logic             cnt_zero;
    logic             busy;
    logic             wr_accept;
    logic             wr_recent;

    assign busy      = is_busy(state);
    // an accepted start in the same cycle takes precedence over a write
    assign wr_accept = wr_en && !busy && (load_src == SRC_NONE);

    rpt_load_sel #(
        .CNT_W (CNT_W),
        .IMM_W (IMM_W)
    ) u_load_sel (
        .start_imm    (start_imm),
        .imm_val      (imm_val),
        .start_reg    (start_reg),
        .cur_cnt      (cnt),
        .wr_recent    (wr_recent),
        .busy         (busy),
        .load_src     (load_src),
        .load_cnt     (load_cnt),
        .load_nonzero (load_nonzero),
        .hazard       (hazard)
    );

    rpt_wr_track u_wr_track (
        .clk       (clk),
        .rst       (rst),
        .wr_accept (wr_accept),
        .wr_recent (wr_recent)
    );

    rpt_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .load_src     (load_src),
        .load_nonzero (load_nonzero),
        .iter_done    (iter_done),
        .cnt_zero     (cnt_zero),
        .irq_enter    (irq_enter),
        .irq_return   (irq_return),
        .state        (state),
        .evt          (evt),
        .reissue      (reissue)
    );

    rpt_count_reg #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk       (clk),
        .rst       (rst),
        .wr_accept (wr_accept),
        .wr_cnt    (wr_data[CNT_W-1:0]),
        .load_src  (load_src),
        .load_cnt  (load_cnt),
        .evt       (evt),
        .cnt       (cnt),
        .cnt_zero  (cnt_zero)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_word = {busy, {PAD_W{1'b0}}, cnt};
        end else begin : g_nopad
            assign rd_word = {busy, cnt};
        end
    endgenerate

    assign active = (state == SEQ_RUN);

endmodule

// File: rtl/rpt_seq_ctrl_chk.sv
module rpt_seq_ctrl_chk #(
    parameter int CNT_W  = 13,
    parameter int IMM_W  = 5,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              start_imm,
    input logic [IMM_W-1:0]  imm_val,
    input logic              iter_done,
    input logic              irq_enter,
    input logic [WORD_W-1:0] rd_word,
    input logic              active,
    input logic              reissue,
    input logic              hazard
);

    logic             flag;
    logic [CNT_W-1:0] cnt;

    assign flag = rd_word[WORD_W-1];
    assign cnt  = rd_word[CNT_W-1:0];

    assert_step_dec_R5: assert property (@(posedge clk) disable iff (rst)
        reissue |=> (cnt == $past(cnt) - CNT_W'(1)));

    assert_reissue_running_R5: assert property (@(posedge clk) disable iff (rst)
        reissue |-> (active && flag));

    assert_clear_on_last_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(flag) && !$past(rst)) |-> ($past(iter_done) && $past(cnt) == '0));

    assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (flag && !active) |=> (flag && $stable(cnt)));

    assert_busy_write_R9: assert property (@(posedge clk) disable iff (rst)
        (flag && wr_en && !iter_done) |=> $stable(cnt));

    assert_hazard_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (hazard && !start_imm) |=> !flag);

endmodule

bind rpt_seq_ctrl rpt_seq_ctrl_chk #(
    .CNT_W  (CNT_W),
    .IMM_W  (IMM_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .start_imm (start_imm),
    .imm_val   (imm_val),
    .iter_done (iter_done),
    .irq_enter (irq_enter),
    .rd_word   (rd_word),
    .active    (active),
    .reissue   (reissue),
    .hazard    (hazard)
);

// File: tb/rpt_seq_ctrl_bench.sv
module rpt_seq_ctrl_bench;

    localparam int VW = 46;
    localparam int NV = 22;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        start_imm = 1'b0;
    logic [4:0]  imm_val = '0;
    logic        start_reg = 1'b0;
    logic        iter_done = 1'b0;
    logic        irq_enter = 1'b0;
    logic        irq_return = 1'b0;
    logic [15:0] rd_word;
    logic        active;
    logic        reissue;
    logic        hazard;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    rpt_seq_ctrl u_rpt_seq_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .start_imm(start_imm), .imm_val(imm_val), .start_reg(start_reg),
        .iter_done(iter_done), .irq_enter(irq_enter), .irq_return(irq_return),
        .rd_word(rd_word), .active(active), .reissue(reissue), .hazard(hazard)
    );

    function automatic logic [VW-1:0] mk(
        input logic wr, input logic [15:0] wd, input logic si, input logic [4:0] im,
        input logic sr, input logic it, input logic ie, input logic ir,
        input logic rs, input logic hz, input logic act, input logic [15:0] word);
        return {wr, wd, si, im, sr, it, ie, ir, rs, hz, act, word};
    endfunction

    //                      wr  wdata     si  imm   sr  it  ie  ir  rs  hz  act word
    localparam logic [VW-1:0] VEC [NV] = '{
        mk(1, 16'hE003, 0, 5'd0,  0, 0, 0, 0, 0, 0, 0, 16'h0003), // R2
        mk(0, 16'h0000, 0, 5'd0,  0, 0, 0, 0, 0, 0, 0, 16'h0003),
        mk(0, 16'h0000, 0, 5'd0,  1, 0, 0, 0, 0, 0, 1, 16'h8003), // R4
        mk(0, 16'h0000, 0, 5'd0,  0, 1, 0, 0, 1, 0, 1, 16'h8002), // R5
        mk(1, 16'h0100, 0, 5'd0,  0, 0, 0, 0, 0, 0, 1, 16'h8002), // R9
        mk(0, 16'h0000, 1, 5'd5,  0, 0, 0, 0, 0, 0, 1, 16'h8002), // R11
        mk(0, 16'h0000, 0, 5'd0,  0, 0, 1, 0, 0, 0, 0, 16'h8002), // R7
        mk(0, 16'h0000, 0, 5'd0,  0, 1, 0, 0, 0, 0, 0, 16'h8002), // R7
        mk(1, 16'h0050, 0, 5'd0,  0, 0, 0, 0, 0, 0, 0, 16'h8002), // R9
        mk(0, 16'h0000, 0, 5'd0,  0, 0, 0, 1, 0, 0, 1, 16'h8002), // R8
        mk(0, 16'h0000, 0, 5'd0,  0, 1, 0, 0, 1, 0, 1, 16'h8001), // R8
        mk(0, 16'h0000, 0, 5'd0,  0, 1, 0, 0, 1, 0, 1, 16'h8000),
        mk(0, 16'h0000, 0, 5'd0,  0, 1, 0, 0, 0, 0, 0, 16'h0000), // R6
        mk(0, 16'h0000, 0, 5'd0,  0, 0, 1, 0, 0, 0, 0, 16'h0000),
        mk(0, 16'h0000, 0, 5'd0,  0, 1, 0, 0, 0, 0, 0, 16'h0000),
        mk(0, 16'h0000, 1, 5'd0,  0, 0, 0, 0, 0, 0, 0, 16'h0000), // R3
        mk(0, 16'h0000, 1, 5'd1,  0, 0, 0, 0, 0, 0, 0, 16'h0000), // R3
        mk(1, 16'h0005, 0, 5'd0,  0, 0, 0, 0, 0, 0, 0, 16'h0005),
        mk(0, 16'h0000, 0, 5'd0,  1, 0, 0, 0, 0, 1, 0, 16'h0005), // R10
        mk(0, 16'h0000, 0, 5'd0,  1, 0, 0, 0, 0, 0, 1, 16'h8005), // R10
        mk(0, 16'h0000, 0, 5'd0,  0, 1, 1, 0, 0, 0, 0, 16'h8004), // R7 same cycle
        mk(0, 16'h0000, 0, 5'd0,  0, 0, 0, 1, 0, 0, 1, 16'h8004)  // R8
    };

    task automatic check(input string req, input string what, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act_v, exp_v);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_data = '0; start_imm = 0; imm_val = '0;
        start_reg = 0; iter_done = 0; irq_enter = 0; irq_return = 0;
    endtask

    // drive a single cycle of idle inputs
    task automatic gap();
        @(negedge clk);
        idle_inputs();
        @(posedge clk);
    endtask

    // pulse iter_done until the flag clears; return completions seen
    task automatic run_out(input string req, input int exp_execs);
        int n = 0;
        int rs = 0;
        while (n < 9000) begin
            @(negedge clk);
            idle_inputs();
            iter_done = 1;
            #1;
            if (reissue) rs++;
            @(posedge clk);
            #1;
            n++;
            if (!rd_word[15]) break;
        end
        @(negedge clk);
        idle_inputs();
        check(req, "executions", n, exp_execs);
        check(req, "reissues", rs, exp_execs - 1);
        check(req, "word after end", int'(rd_word), 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check("R1", "rd_word after reset", int'(rd_word), 0);
        check("R1", "active after reset", int'(active), 0);
        check("R1", "reissue after reset", int'(reissue), 0);
        check("R1", "hazard after reset", int'(hazard), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            @(negedge clk);
            wr_en      = v[45];
            wr_data    = v[44:29];
            start_imm  = v[28];
            imm_val    = v[27:23];
            start_reg  = v[22];
            iter_done  = v[21];
            irq_enter  = v[20];
            irq_return = v[19];
            #1;
            check($sformatf("vec%0d", i), "reissue", int'(reissue), int'(v[18]));
            check($sformatf("vec%0d", i), "hazard", int'(hazard), int'(v[17]));
            @(posedge clk);
            #1;
            check($sformatf("vec%0d", i), "active", int'(active), int'(v[16]));
            check($sformatf("vec%0d", i), "rd_word", int'(rd_word), int'(v[15:0]));
        end

        // R6: resumed sequence holds count 4, so 5 more completions
        run_out("R6", 5);

        // R3 and R6: immediate 24 gives count 23 and 24 executions
        @(negedge clk);
        start_imm = 1; imm_val = 5'd24;
        @(posedge clk);
        #1;
        check("R3", "imm 24 word", int'(rd_word), 16'h8017);
        run_out("R3", 24);

        // R4 and R6: register count 0x00FF gives 256 executions
        @(negedge clk);
        wr_en = 1; wr_data = 16'h00FF;
        @(posedge clk);
        gap();
        @(negedge clk);
        idle_inputs();
        start_reg = 1;
        @(posedge clk);
        #1;
        check("R4", "reg start word", int'(rd_word), 16'h80FF);
        run_out("R4", 256);

        // R12: both starts together, immediate wins (7 would be kept by register mode)
        @(negedge clk);
        wr_en = 1; wr_data = 16'h0007;
        @(posedge clk);
        gap();
        @(negedge clk);
        idle_inputs();
        start_imm = 1; imm_val = 5'd3; start_reg = 1;
        @(posedge clk);
        #1;
        check("R12", "priority word", int'(rd_word), 16'h8002);
        run_out("R12", 3);

        // R1: reset in the middle of a sequence
        @(negedge clk);
        start_imm = 1; imm_val = 5'd10;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check("R1", "word after mid reset", int'(rd_word), 0);
        check("R1", "active after mid reset", int'(active), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule